// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Conversion Controller

This block is the digital half of one successive-approximation ADC channel. After a start strobe it runs a fixed-length sampling phase, then resolves a 9-bit code one bit at a time, most significant bit first. A one-hot pointer marks the bit under test. A decision register holds every bit resolved so far. Together they form the word sent to the capacitor DAC. Each trial is judged by a clocked latch comparator that the block drives through a dedicated comparator clock.

Two stepping modes are supported. In the fixed-slot mode every bit gets the same worst-case evaluation window, so a conversion always takes the same number of cycles. In the self-timed mode the controller watches the comparator's two precharged outputs. As soon as they differ it takes the decision, precharges the comparator for a minimum interval, and launches the next trial.

If the comparator fails to resolve within its allowance, the block treats it as metastable. It forces the bit under test to 1, leaves all lower bits at 0, raises a sticky error flag and finishes the conversion with the usual done pulse.

Top module: `sar_async_ctrl`

## Requirements
- R1: After reset the comparator clock, DAC word, done flag, error flag and code output are all zero.
- R2: For SLOT = EVAL_CYC + RST_CYC cycles after a start is accepted, the DAC word is all zeros and the comparator clock is low.
- R3: At each rising edge of the comparator clock, the DAC word equals the bits already decided, plus a single trial bit. The trial bit starts at bit 8 and moves down one position per decision. A decision is 1 when cmp_p_i=1 and cmp_n_i=0, meaning the input lies at or above the trial level.
- R4: The code output carries the binary-search result. done_o is high for exactly one cycle when the code becomes available.
- R5: In fixed-slot mode (async_mode_i=0), a conversion takes exactly 11*SLOT cycles from the start edge to done, whatever the comparator delay up to EVAL_CYC cycles.
- R6: In self-timed mode (async_mode_i=1), a comparator resolving in d cycles gives a conversion time of 2*SLOT + 9*(d + RST_CYC) cycles.
- R7: Between two evaluations, the comparator clock stays low for at least RST_CYC cycles.
- R8: A decision is taken only while the two comparator outputs differ. Equal outputs, whether both low or both high, count as unresolved. A comparator still unresolved after TMO_CYC cycles (self-timed mode), or at the end of its EVAL_CYC slot (fixed-slot mode), is treated as metastable.
- R9: On a metastable decision the bit under test becomes 1 and all lower bits become 0. meta_err_o rises, stays high until the next start is accepted, and the conversion still ends with a done pulse.
- R10: A start strobe that arrives while a conversion is running is ignored. It changes neither the code nor the conversion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-conversion / sample strobe |
| async_mode_i | input | 1 | 1 = self-timed stepping, 0 = fixed slots |
| cmp_p_i | input | 1 | Comparator positive latch output |
| cmp_n_i | input | 1 | Comparator negative latch output |
| cmp_clk_o | output | 1 | Comparator clock, high while evaluating |
| dac_o | output | 9 | DAC control word |
| code_o | output | 9 | Final conversion result |
| done_o | output | 1 | One-cycle result-valid strobe |
| meta_err_o | output | 1 | Sticky metastability flag for the last sample |

## Verification
A corrupted pointer or decision register shows up first on the DAC word. At the next rising edge of the comparator clock it is compared against the trial value expected from the search, so the error surfaces within one bit step. A sequencing fault shows up in the cycle count from start to done, which is exact in both modes. It also shows up in the length of each comparator-clock low phase. A metastability path that forces the wrong bits, or forgets the flag, shows up in the code and in meta_err_o when done is pulsed. A stale flag shows up at the next start.

// File: rtl/sar_ctrl_pkg.sv
// Shared types for the SAR conversion controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_ctrl_pkg;

    // Conversion sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_EVAL   = 3'd2,
        ST_PRECH  = 3'd3,
        ST_FINAL  = 3'd4
    } seq_state_e;

    // Counter width able to hold the larger of two cycle counts
    function automatic int cnt_width(input int a, input int b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction

endpackage

// File: rtl/sar_split_detect.sv
// Comparator decision detector.
// Watches the two latch outputs while the comparator clock is high. It issues a
// single resolve strobe when the outputs split (self-timed mode), when the fixed
// evaluation slot ends (slot mode), or when the self-timed allowance runs out.
// Assumes: the comparator outputs are stable around the sampling clock edge, and
// the sequencer drops the comparator clock in the cycle after resolve.
module sar_split_detect #(
    parameter int EVAL_CYC = 6,
    parameter int TMO_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_clk_i,
    input  logic async_i,
    input  logic cmp_p_i,
    input  logic cmp_n_i,
    output logic resolve_o,
    output logic bit_o,
    output logic meta_o
);
    localparam int CW = sar_ctrl_pkg::cnt_width(EVAL_CYC, TMO_CYC);
    localparam logic [CW-1:0] EVAL_LIM = CW'(EVAL_CYC - 1);
    localparam logic [CW-1:0] TMO_LIM  = CW'(TMO_CYC - 1);

    logic [CW-1:0] ecnt;
    logic          split;
    logic [CW-1:0] lim;

    // Count cycles spent evaluating; cleared while precharging
    always_ff @(posedge clk) begin
        if (!rst_n)            ecnt <= '0;
        else if (!cmp_clk_i)   ecnt <= '0;
        else if (ecnt != '1)   ecnt <= ecnt + CW'(1);
    end

    // Decide when a decision is taken and what it is
    always_comb begin
        split     = cmp_p_i ^ cmp_n_i;
        lim       = async_i ? TMO_LIM : EVAL_LIM;
        resolve_o = cmp_clk_i && ((async_i && split) || (ecnt == lim));
        bit_o     = split & cmp_p_i;
        meta_o    = !split;
    end

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (async_i && cmp_clk_i) |-> (ecnt <= TMO_LIM)); // R8
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_i && cmp_clk_i) |-> (ecnt <= EVAL_LIM)); // R5

endmodule

// File: rtl/sar_bit_regs.sv
// Pointer and decision registers of the successive-approximation search.
// The pointer is one-hot, is loaded with the MSB and shifts right once per
// decision. Each decision bit is written only while the pointer selects it.
// Assumes: load_i and take_i are never high together.
module sar_bit_regs #(
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             take_i,
    input  logic             bit_i,
    input  logic             meta_i,
    output logic [NBITS-1:0] ptr_o,
    output logic [NBITS-1:0] dec_o
);
    localparam logic [NBITS-1:0] MSB_ONEHOT = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] ptr_q;
    logic [NBITS-1:0] dec_q;

    // Bit pointer: MSB on load, shift right per decision, cleared on metastability
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= MSB_ONEHOT;
        else if (take_i) ptr_q <= meta_i ? '0 : (ptr_q >> 1);
    end

    // One decision flop per bit, written when the pointer is on it
    for (genvar i = 0; i < NBITS; i++) begin : g_dec
        always_ff @(posedge clk) begin
            if (!rst_n)                     dec_q[i] <= 1'b0;
            else if (load_i)                dec_q[i] <= 1'b0;
            else if (take_i && ptr_q[i])    dec_q[i] <= meta_i | bit_i;
        end
    end

    assign ptr_o = ptr_q;
    assign dec_o = dec_q;

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q)); // R3
    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|ptr_q) |-> ((dec_q & (ptr_q - NBITS'(1))) == '0)); // R3

endmodule

// File: rtl/sar_sequencer.sv
// Conversion sequencer. It runs the phases sample, evaluate, precharge
// (repeated per bit) and final reset slot. It drives the comparator clock,
// registers the code with a one-cycle done strobe, and keeps the sticky
// metastability flag.
// Assumes: resolve_i is a single-cycle strobe valid only while evaluating.
module sar_sequencer #(
    parameter int NBITS    = 9,
    parameter int EVAL_CYC = 6,
    parameter int RST_CYC  = 2,
    parameter int TMO_CYC  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             resolve_i,
    input  logic             meta_i,
    input  logic             ptr_zero_i,
    input  logic [NBITS-1:0] dec_i,
    output logic             load_o,
    output logic             sampling_o,
    output logic             cmp_clk_o,
    output logic             done_o,
    output logic [NBITS-1:0] code_o,
    output logic             meta_err_o
);
    import sar_ctrl_pkg::*;

    localparam int SLOT = EVAL_CYC + RST_CYC;
    localparam int CW   = cnt_width(SLOT, TMO_CYC);
    localparam int RW   = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] SLOT_LIM = CW'(SLOT - 1);
    localparam logic [CW-1:0] RST_LIM  = CW'(RST_CYC - 1);

    seq_state_e       state, state_d;
    logic [CW-1:0]    cnt, cnt_d;
    logic             fin;
    logic             cmp_clk_q;
    logic             done_q;
    logic [NBITS-1:0] code_q;
    logic             meta_q;
    logic [RW-1:0]    lowrun;

    // Next-phase and phase-counter decode
    always_comb begin
        state_d = state;
        cnt_d   = cnt + CW'(1);
        load_o  = 1'b0;
        fin     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    state_d = ST_SAMPLE;
                    load_o  = 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (cnt == SLOT_LIM) begin
                    state_d = ST_EVAL;
                    cnt_d   = '0;
                end
            end
            ST_EVAL: begin
                cnt_d = '0;
                if (resolve_i) state_d = meta_i ? ST_FINAL : ST_PRECH;
            end
            ST_PRECH: begin
                if (cnt == RST_LIM) begin
                    cnt_d   = '0;
                    state_d = ptr_zero_i ? ST_FINAL : ST_EVAL;
                end
            end
            ST_FINAL: begin
                if (cnt == SLOT_LIM) begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase registers and glitch-free comparator clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cmp_clk_q <= 1'b0;
        end else begin
            state     <= state_d;
            cnt       <= cnt_d;
            cmp_clk_q <= (state_d == ST_EVAL);
        end
    end

    // Result register and one-cycle done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= '0;
        end else begin
            done_q <= fin;
            if (fin) code_q <= dec_i;
        end
    end

    // Sticky metastability flag, cleared when a new sample starts
    always_ff @(posedge clk) begin
        if (!rst_n)                                          meta_q <= 1'b0;
        else if (load_o)                                     meta_q <= 1'b0;
        else if (state == ST_EVAL && resolve_i && meta_i)    meta_q <= 1'b1;
    end

    // Length of the current comparator-clock low phase (checking aid)
    always_ff @(posedge clk) begin
        if (!rst_n)                       lowrun <= '0;
        else if (cmp_clk_q)               lowrun <= '0;
        else if (lowrun != RW'(RST_CYC))  lowrun <= lowrun + RW'(1);
    end

    assign sampling_o = (state == ST_SAMPLE);
    assign cmp_clk_o  = cmp_clk_q;
    assign done_o     = done_q;
    assign code_o     = code_q;
    assign meta_err_o = meta_q;

    AST_RST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_clk_q) |-> (lowrun >= RW'(RST_CYC))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R4
    AST_META_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q && !load_o) |=> meta_q); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !(state == ST_SAMPLE && cnt == '0)); // R10

endmodule

// File: rtl/sar_async_ctrl.sv
// Top of the SAR conversion controller for one ADC channel. It connects the
// sequencer, the split detector and the pointer/decision registers, and forms
// the DAC word: zero while sampling, otherwise the decided bits plus the trial bit.
// Assumes: async_mode_i is static during a conversion; the comparator outputs
// are reset to equal levels while cmp_clk_o is low.
module sar_async_ctrl #(
    parameter int NBITS    = 9,
    parameter int EVAL_CYC = 6,
    parameter int RST_CYC  = 2,
    parameter int TMO_CYC  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             async_mode_i,
    input  logic             cmp_p_i,
    input  logic             cmp_n_i,
    output logic             cmp_clk_o,
    output logic [NBITS-1:0] dac_o,
    output logic [NBITS-1:0] code_o,
    output logic             done_o,
    output logic             meta_err_o
);
    logic             load;
    logic             sampling;
    logic             resolve;
    logic             dec_bit;
    logic             meta;
    logic [NBITS-1:0] ptr;
    logic [NBITS-1:0] dec;
    logic             cmp_clk;

    sar_sequencer #(
        .NBITS(NBITS), .EVAL_CYC(EVAL_CYC), .RST_CYC(RST_CYC), .TMO_CYC(TMO_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .resolve_i  (resolve),
        .meta_i     (meta),
        .ptr_zero_i (ptr == '0),
        .dec_i      (dec),
        .load_o     (load),
        .sampling_o (sampling),
        .cmp_clk_o  (cmp_clk),
        .done_o     (done_o),
        .code_o     (code_o),
        .meta_err_o (meta_err_o)
    );

    sar_split_detect #(
        .EVAL_CYC(EVAL_CYC), .TMO_CYC(TMO_CYC)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_clk_i (cmp_clk),
        .async_i   (async_mode_i),
        .cmp_p_i   (cmp_p_i),
        .cmp_n_i   (cmp_n_i),
        .resolve_o (resolve),
        .bit_o     (dec_bit),
        .meta_o    (meta)
    );

    sar_bit_regs #(
        .NBITS(NBITS)
    ) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .take_i (resolve),
        .bit_i  (dec_bit),
        .meta_i (meta),
        .ptr_o  (ptr),
        .dec_o  (dec)
    );

    // DAC word: blank during sampling, decided bits plus trial bit otherwise
    always_comb begin
        dac_o = sampling ? '0 : (dec | ptr);
    end

    assign cmp_clk_o = cmp_clk;

endmodule

// File: tb/sar_async_ctrl_tb.sv
// Directed bench with an ideal behavioural comparator of programmable delay.
module sar_async_ctrl_tb_top;
    localparam int NB   = 9;
    localparam int EV   = 6;
    localparam int RS   = 2;
    localparam int TM   = 12;
    localparam int SLOT = EV + RS;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, amode = 1'b0;
    logic cp = 1'b0, cn = 1'b0;
    logic cmp_clk, done, meta;
    logic [NB-1:0] dac, code;

    int n_chk = 0, n_fail = 0;
    int m_vin = 0, m_delay = 1, m_hang = -1, hc = 0;
    bit m_both = 0;

    always #5 clk = ~clk;

    sar_async_ctrl #(.NBITS(NB), .EVAL_CYC(EV), .RST_CYC(RS), .TMO_CYC(TM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .async_mode_i(amode),
        .cmp_p_i(cp), .cmp_n_i(cn), .cmp_clk_o(cmp_clk), .dac_o(dac),
        .code_o(code), .done_o(done), .meta_err_o(meta));

    function automatic int low_bit(input logic [NB-1:0] v);
        for (int i = 0; i < NB; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Ideal comparator: precharged low, resolves m_delay cycles into evaluation
    always @(negedge clk) begin
        if (!cmp_clk) begin
            cp = 1'b0; cn = 1'b0; hc = 0;
        end else begin
            hc = hc + 1;
            if (m_hang >= 0 && low_bit(dac) == m_hang) begin
                cp = 1'b0; cn = 1'b0;
            end else if (hc >= m_delay) begin
                cp = (m_vin >= int'(dac)); cn = !cp;
            end else begin
                cp = m_both; cn = m_both;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input int vin, input bit am, input int dly, input int hang,
                            input bit both, input bit glitch,
                            output logic [NB-1:0] rcode, output int cyc, output bit trials_ok,
                            output bit sample_ok, output int minlow, output bit meta_start,
                            output bit pulse_ok, output bit meta_end);
        logic [NB-1:0] dec_e, exp_t;
        int k, lowrun;
        bit prev, seen;
        m_vin = vin; amode = am; m_delay = dly; m_hang = hang; m_both = both;
        dec_e = '0; k = 0; lowrun = 0; prev = 0; seen = 0;
        trials_ok = 1; minlow = 1000; cyc = 0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        sample_ok  = (dac == '0) && !cmp_clk;
        meta_start = meta;
        while (1) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            start = (glitch && cyc == 30);
            if (cyc < SLOT && (dac != '0 || cmp_clk)) sample_ok = 0;
            if (cmp_clk && !prev) begin
                if (seen && lowrun < minlow) minlow = lowrun;
                seen = 1;
                exp_t = dec_e | (NB'(1) << (NB - 1 - k));
                if (dac !== exp_t) trials_ok = 0;
                if (vin >= int'(exp_t)) dec_e = exp_t;
                k++;
            end
            if (!cmp_clk) lowrun++; else lowrun = 0;
            prev = cmp_clk;
            if (done || cyc > 2000) break;
        end
        rcode    = code;
        meta_end = meta;
        @(posedge clk);
        @(negedge clk);
        pulse_ok = !done;
    endtask

    task automatic t_reset();
        chk(cmp_clk == 1'b0, "R1 cmp_clk", int'(cmp_clk), 0);
        chk(dac == '0, "R1 dac", int'(dac), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(meta == 1'b0, "R1 meta_err", int'(meta), 0);
        chk(code == '0, "R1 code", int'(code), 0);
    endtask

    task automatic t_sync(input int vin);
        logic [NB-1:0] c; int cyc, ml; bit tr, so, ms, po, me;
        run_conv(vin, 0, 3, -1, 0, 0, c, cyc, tr, so, ml, ms, po, me);
        chk(so, "R2 sample blank", int'(so), 1);
        chk(tr, "R3 trial sequence", int'(tr), 1);
        chk(int'(c) == vin, "R4 code", int'(c), vin);
        chk(po, "R4 done single", int'(po), 1);
        chk(cyc == 11 * SLOT, "R5 slot timing", cyc, 11 * SLOT);
        chk(ml == RS, "R7 reset interval", ml, RS);
        chk(!me, "R9 no meta", int'(me), 0);
    endtask

    task automatic t_async(input int vin, input int dly, input bit both);
        logic [NB-1:0] c; int cyc, ml; bit tr, so, ms, po, me;
        run_conv(vin, 1, dly, -1, both, 0, c, cyc, tr, so, ml, ms, po, me);
        chk(tr, "R3 async trials", int'(tr), 1);
        chk(int'(c) == vin, both ? "R8 equal-high ignored code" : "R4 async code", int'(c), vin);
        chk(cyc == 2 * SLOT + NB * (dly + RS), both ? "R8 equal-high timing" : "R6 async timing",
            cyc, 2 * SLOT + NB * (dly + RS));
        chk(ml >= RS, "R7 async reset interval", ml, RS);
        chk(po, "R4 async done single", int'(po), 1);
    endtask

    task automatic t_sync_meta();
        logic [NB-1:0] c; int cyc, ml; bit tr, so, ms, po, me;
        run_conv(32'h0F0, 0, EV + 4, -1, 0, 0, c, cyc, tr, so, ml, ms, po, me);
        chk(c == 9'h100, "R8 slot-end unresolved forces MSB", int'(c), 32'h100);
        chk(me, "R9 meta flag on slot timeout", int'(me), 1);
        chk(po, "R9 done still pulses once", int'(po), 1);
    endtask

    task automatic t_async_meta();
        logic [NB-1:0] c; int cyc, ml; bit tr, so, ms, po, me;
        run_conv(32'h1A7, 1, 2, 4, 0, 0, c, cyc, tr, so, ml, ms, po, me);
        chk(c == 9'h1B0, "R9 forced bit and cleared lower bits", int'(c), 32'h1B0);
        chk(me, "R9 meta flag on timeout", int'(me), 1);
        chk(cyc == 2 * SLOT + 4 * (2 + RS) + TM, "R8 timeout after allowance",
            cyc, 2 * SLOT + 4 * (2 + RS) + TM);
        repeat (5) @(negedge clk);
        chk(meta, "R9 meta sticky while idle", int'(meta), 1);
        run_conv(32'h0C3, 1, 2, -1, 0, 0, c, cyc, tr, so, ml, ms, po, me);
        chk(!ms, "R9 meta cleared at start", int'(ms), 0);
        chk(!me && c == 9'h0C3, "R9 clean conversion after meta", int'(c), 32'h0C3);
    endtask

    task automatic t_start_ignore();
        logic [NB-1:0] c; int cyc, ml; bit tr, so, ms, po, me;
        run_conv(32'h12D, 0, 2, -1, 0, 1, c, cyc, tr, so, ml, ms, po, me);
        chk(int'(c) == 32'h12D, "R10 code unchanged by late start", int'(c), 32'h12D);
        chk(cyc == 11 * SLOT, "R10 timing unchanged by late start", cyc, 11 * SLOT);
        chk(po, "R10 single done", int'(po), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_sync(32'h155);
        t_sync(0);
        t_sync(511);
        t_sync(256);
        t_sync(255);
        t_async(32'h0AA, 1, 0);
        t_async(32'h1F3, 4, 0);
        t_async(32'h081, 4, 1);
        t_sync_meta();
        t_async_meta();
        t_start_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule